// File: doc/BRIEF.md
# PHY Configuration Sequencer over an Indirect Register Port

This block is a small bus master. It loads a fixed set of configuration values into a PHY through an indirect register pair. One register holds a PHY-internal address. The other takes the data word, with command flags in its upper bits. Every PHY register update costs three bus writes:

1. The address is written.
2. The data is written with the capture flag set.
3. The same data is written again with the write-enable flag set.

The block walks a built-in two-entry table. It then reports completion with a single-cycle pulse.

The surrounding logic pulses `start` once the PHY reset sequence has finished. The reset outcome is presented on `phy_rst_ok` in that same cycle. A start that arrives with a failed reset outcome is dropped, and no bus traffic follows. Each bus write is a valid/ready transfer that stays on the bus until the target accepts it.

Top module: `phy_cfg_writer`

## Requirements
- R1: While and right after reset, `wr_valid`, `busy` and `done` are low.
- R2: A `start` pulse is taken only when `phy_rst_ok` is 1 in the same cycle. If `phy_rst_ok` is 0, no write is issued and `busy` stays low.
- R3: Each table entry produces three writes:
  - offset 0x00, with the 16-bit PHY address in bits 15:0 and zeros above;
  - offset 0x04, with the 16-bit data in bits 15:0 and bit 18 (capture) set;
  - offset 0x04, with the same data and bit 17 (write enable) set.
  Bit 16 (read enable) is never set, and all other upper bits are zero.
- R4: The entries go out in this order: PHY address 0x0014 with data 0xCE10, then PHY address 0x2004 with data 0x82C7. One run is exactly six writes.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_offset` and `wr_data` hold their values into the next cycle. A write completes in a cycle where both are high, and only one write is outstanding at a time.
- R6: A `start` pulse that arrives while `busy` is high has no effect. The run in progress is neither restarted nor extended.
- R7: `done` is high for exactly one cycle, the cycle after the last commit write is accepted. In that cycle `busy` and `wr_valid` are low.
- R8: `busy` rises in the cycle after an accepted `start` and stays high until the last write is accepted. `wr_valid` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the configuration table |
| phy_rst_ok | input | 1 | PHY reset completed successfully; qualifies `start` |
| wr_ready | input | 1 | Bus target accepts the current write |
| wr_valid | output | 1 | A write is presented on the bus |
| wr_offset | output | OFS_W (8) | Register offset of the write |
| wr_data | output | DATA_W (32) | Write data word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `wr_ready` is a plain level that the target may raise or drop in any cycle. They do not assume it waits for `wr_valid`.

The assertions also assume that reset is held for at least one clock edge before any checked cycle.

The stimulus drives `wr_ready` from a seeded random source at several acceptance rates, including always-ready. It changes it only just after the rising edge, so every handshake is decided by settled levels. Start pulses are issued both in idle and in the middle of a run, with `phy_rst_ok` at either value.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    // Register offsets of the indirect pair and command bit positions
    localparam int unsigned IDX_REG_OFS  = 0;
    localparam int unsigned CMD_REG_OFS  = 4;
    localparam int unsigned FLAG_RD_BIT  = 16;
    localparam int unsigned FLAG_WR_BIT  = 17;
    localparam int unsigned FLAG_CAP_BIT = 18;
    localparam int unsigned FIELD_W      = 16;

    localparam int unsigned TABLE_LEN = 2;

    typedef enum logic [1:0] {
        STEP_ADDR   = 2'd0,
        STEP_LATCH  = 2'd1,
        STEP_COMMIT = 2'd2
    } step_e;

    typedef struct packed {
        logic [FIELD_W-1:0] reg_addr;
        logic [FIELD_W-1:0] reg_val;
    } tbl_entry_t;

    function automatic tbl_entry_t tbl_lookup(input int unsigned idx);
        tbl_entry_t e;
        case (idx)
            0:       e = '{reg_addr: 16'h0014, reg_val: 16'hCE10};
            1:       e = '{reg_addr: 16'h2004, reg_val: 16'h82C7};
            default: e = '{reg_addr: 16'h0000, reg_val: 16'h0000};
        endcase
        return e;
    endfunction

    function automatic step_e step_next(input step_e s);
        case (s)
            STEP_ADDR:  return STEP_LATCH;
            STEP_LATCH: return STEP_COMMIT;
            default:    return STEP_ADDR;
        endcase
    endfunction

endpackage

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
    import phy_cfg_pkg::*;
#(
    parameter int unsigned N_ENTRIES = TABLE_LEN,
    parameter int unsigned IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             phy_rst_ok,
    input  logic             accept,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx,
    output step_e            step
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    logic last_write;
    assign last_write = (step == STEP_COMMIT) && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
            step <= STEP_ADDR;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start && phy_rst_ok) begin
                    busy <= 1'b1;
                    idx  <= '0;
                    step <= STEP_ADDR;
                end
            end else if (accept) begin
                step <= step_next(step);
                if (last_write) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    idx  <= '0;
                end else if (step == STEP_COMMIT) begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/phy_cfg_word.sv
module phy_cfg_word
    import phy_cfg_pkg::*;
#(
    parameter int unsigned IDX_W  = 1,
    parameter int unsigned OFS_W  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic [IDX_W-1:0]  idx,
    input  step_e             step,
    output logic [OFS_W-1:0]  offset,
    output logic [DATA_W-1:0] data
);
    tbl_entry_t ent;
    assign ent = tbl_lookup(int'(idx));

    always_comb begin
        offset = OFS_W'(CMD_REG_OFS);
        data   = '0;
        case (step)
            STEP_ADDR: begin
                offset              = OFS_W'(IDX_REG_OFS);
                data[FIELD_W-1:0]   = ent.reg_addr;
            end
            STEP_LATCH: begin
                data[FIELD_W-1:0]   = ent.reg_val;
                data[FLAG_CAP_BIT]  = 1'b1;
            end
            default: begin
                data[FIELD_W-1:0]   = ent.reg_val;
                data[FLAG_WR_BIT]   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/phy_cfg_writer.sv
module phy_cfg_writer
    import phy_cfg_pkg::*;
#(
    parameter int unsigned OFS_W  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              phy_rst_ok,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [OFS_W-1:0]  wr_offset,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);
    localparam int unsigned IDX_W = (TABLE_LEN > 1) ? $clog2(TABLE_LEN) : 1;

    logic [IDX_W-1:0] cur_idx;
    step_e            cur_step;

    phy_cfg_seq #(
        .N_ENTRIES (TABLE_LEN),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .phy_rst_ok (phy_rst_ok),
        .accept     (wr_ready),
        .busy       (busy),
        .done       (done),
        .idx        (cur_idx),
        .step       (cur_step)
    );

    phy_cfg_word #(
        .IDX_W  (IDX_W),
        .OFS_W  (OFS_W),
        .DATA_W (DATA_W)
    ) u_word (
        .idx    (cur_idx),
        .step   (cur_step),
        .offset (wr_offset),
        .data   (wr_data)
    );

    assign wr_valid = busy;

endmodule

// File: rtl/phy_cfg_writer_chk.sv
module phy_cfg_writer_chk #(
    parameter int unsigned OFS_W  = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [OFS_W-1:0]  wr_offset,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              done
);
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_offset) && $stable(wr_data)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !wr_valid));

    p_no_read_flag_r3: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !wr_data[16]);

    p_addr_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_offset == '0) |-> (wr_data[DATA_W-1:16] == '0));

    p_valid_in_run_r8: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);

    p_busy_ends_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

bind phy_cfg_writer phy_cfg_writer_chk #(
    .OFS_W  (OFS_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_offset (wr_offset),
    .wr_data   (wr_data),
    .busy      (busy),
    .done      (done)
);

// File: tb/phy_cfg_writer_bench.sv
module phy_cfg_writer_bench;
    localparam int OFS_W  = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              phy_rst_ok = 1'b0;
    logic              wr_ready = 1'b0;
    logic              wr_valid;
    logic [OFS_W-1:0]  wr_offset;
    logic [DATA_W-1:0] wr_data;
    logic              busy;
    logic              done;

    int checks = 0;
    int errors = 0;
    int ready_pct = 100;
    int wr_count = 0;
    int done_count = 0;
    int cycles = 0;
    bit prev_final = 1'b0;
    bit prev_wait = 1'b0;
    logic [OFS_W-1:0]  held_ofs;
    logic [DATA_W-1:0] held_data;

    always #4 clk = ~clk;

    phy_cfg_writer #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_phy_cfg_writer (
        .clk(clk), .rst(rst), .start(start), .phy_rst_ok(phy_rst_ok),
        .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_offset(wr_offset),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    // Expected k-th write of a run, from R3 and R4
    function automatic logic [OFS_W-1:0] exp_ofs(input int k);
        return (k % 3 == 0) ? OFS_W'(0) : OFS_W'(4);
    endfunction

    function automatic logic [DATA_W-1:0] exp_data(input int k);
        logic [15:0] a, d;
        a = (k / 3 == 0) ? 16'h0014 : 16'h2004;
        d = (k / 3 == 0) ? 16'hCE10 : 16'h82C7;
        case (k % 3)
            0:       return {16'h0000, a};
            1:       return {13'd0, 3'b100, d};
            default: return {13'd0, 3'b010, d};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1 wr_ready <= ($urandom_range(0, 99) < ready_pct);
    end

    // Bus monitor
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            if (prev_wait) begin
                check(wr_valid && wr_offset == held_ofs && wr_data == held_data,
                      "R5", "held word", {wr_valid, wr_offset, wr_data},
                      {1'b1, held_ofs, held_data});
            end
            if (prev_final || done) begin
                check(done == prev_final, "R7", "done pulse", done, prev_final);
                if (done) begin
                    check(!busy, "R7", "busy with done", busy, 0);
                    done_count++;
                end
            end
            prev_final = 1'b0;
            prev_wait = wr_valid && !wr_ready;
            held_ofs = wr_offset;
            held_data = wr_data;
            if (wr_valid && wr_ready) begin
                if (wr_count < 6) begin
                    check(wr_offset == exp_ofs(wr_count), "R3", "offset",
                          wr_offset, exp_ofs(wr_count));
                    check(wr_data == exp_data(wr_count), "R4", "data",
                          wr_data, exp_data(wr_count));
                end else begin
                    check(1'b0, "R6", "extra write", wr_count, 5);
                end
                if (wr_count == 5) prev_final = 1'b1;
                wr_count++;
            end
        end else begin
            prev_wait = 1'b0;
            prev_final = 1'b0;
        end
    end

    task automatic pulse_start(input bit ok);
        @(posedge clk); #1;
        start = 1'b1; phy_rst_ok = ok;
        @(posedge clk); #1;
        start = 1'b0; phy_rst_ok = 1'b0;
    endtask

    task automatic run_table(input int pct, input bit poke_busy);
        int seen;
        ready_pct = pct;
        wr_count = 0;
        seen = done_count;
        pulse_start(1'b1);
        @(negedge clk);
        check(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (poke_busy) begin
            repeat (2) @(posedge clk);
            #1 start = 1'b1; phy_rst_ok = 1'b1;
            @(posedge clk); #1 start = 1'b0; phy_rst_ok = 1'b0;
        end
        for (int i = 0; i < 3000 && done_count == seen; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(wr_count == 6, "R4", "writes per run", wr_count, 6);
        check(done_count == seen + 1, "R7", "done pulses", done_count - seen, 1);
        check(!busy && !wr_valid, "R8", "idle after run", {busy, wr_valid}, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!wr_valid && !busy && !done, "R1", "reset outputs",
              {wr_valid, busy, done}, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!wr_valid && !busy && !done, "R1", "after reset",
              {wr_valid, busy, done}, 0);

        run_table(100, 1'b0);
        run_table(35, 1'b0);
        run_table(70, 1'b1);   // R6: start while busy
        run_table(10, 1'b1);   // R6 with long stalls

        // R2: failed PHY reset drops start
        wr_count = 0;
        ready_pct = 100;
        pulse_start(1'b0);
        repeat (20) @(negedge clk);
        check(wr_count == 0 && !busy, "R2", "writes after failed reset",
              wr_count, 0);

        for (int r = 0; r < 4; r++) run_table(int'($urandom_range(5, 100)), r[0]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule